// File: doc/BRIEF.md
# Quarterbit Frame Timebase

This block is the frame timebase of a TDMA terminal. A counter advances once for each quarterbit tick and runs from 0 to `FRAME_LEN-1`. It then wraps back to 0, so a frame lasts `FRAME_LEN` ticks (5000 by default). Each wrap is a frame start. At a frame start the block pulls an active-low frame interrupt to the host. The interrupt stays low until the host touches the mode register.

The host corrects timing through a small register strobe interface.

- **Coarse correction.** The host loads a correction value and raises a one-shot resync request. At the end of the current frame the counter is loaded with that value. The next frame is therefore shortened to `FRAME_LEN - value` ticks. During that corrective frame the interrupt at its start is withheld and the timing-enable output is low.
- **Fine correction.** The host raises a one-shot request to stretch or shrink the next frame by exactly one tick.

Downstream burst logic only runs while timing-enable is high.

Register map (word address on `host_addr`):
- 0: mode. Bit 0 disables the frame interrupt. Any read or write strobe at this address releases the interrupt.
- 1: correction value, `CNT_W` bits.
- 2: requests, written as ones to set. Bit 0 is resync, bit 1 is stretch, bit 2 is shrink.

Top module: `qbt_timebase`

## Requirements
- R1: Each cycle with `tick` high moves `count` up by one. With `tick` low, `count` is unchanged. From `FRAME_LEN-1` a tick returns `count` to 0, so a normal frame spans `FRAME_LEN` ticks.
- R2: A synchronous reset (`rst` high) sets `count` to 0 and `frame_irq_n` to 1 and `timing_en` to 1. It also discards any pending resync, stretch or shrink request.
- R3: The cycle after a frame-start tick, `frame_irq_n` reads 0. It stays 0 until a read or write strobe at address 0. That strobe returns it to 1 on the following cycle. A strobe at any other address leaves it low.
- R4: After a write of 1 to address 2 bit 0, the next frame-end tick loads `count` with the correction value. The corrective frame then lasts `FRAME_LEN - value` ticks. `frame_irq_n` is not driven low by that frame-end tick. `timing_en` is 0 for the whole corrective frame. At the next frame start the interrupt fires and `timing_en` returns to 1.
- R5: The resync request clears itself once applied. The frame after the corrective frame has the normal length.
- R6: A correction value of `FRAME_LEN` or more is treated as `FRAME_LEN-1`, which gives a one-tick corrective frame. A value of 0 gives a corrective frame of full length.
- R7: A write of 1 to address 2 bit 1 makes the next frame hold `count` at 0 for two ticks. That frame lasts `FRAME_LEN+1` ticks, and only that frame.
- R8: A write of 1 to address 2 bit 2 makes the next frame step from 0 straight to 2. That frame lasts `FRAME_LEN-1` ticks, and only that frame.
- R9: If the stretch and shrink requests are pending together, both are dropped at the next frame start. No frame changes length.
- R10: If a resync is pending together with a stretch or shrink request, the resync is applied first. The one-tick request stays pending and acts at the start of the frame after the corrective frame.
- R11: With address 0 bit 0 set, frame starts leave `frame_irq_n` high. Writing zero bits to address 2 requests nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Quarterbit step enable |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 2 | Register word address |
| host_wdata | input | CNT_W | Register write data |
| count | output | CNT_W | Current position within the frame |
| frame_irq_n | output | 1 | Frame interrupt, active low |
| timing_en | output | 1 | Low during a corrective resync frame |

## Verification
The assertions check the following on every cycle:
- `count` stays in range.
- `count` holds when there is no tick, and each tick steps it by one, by zero (stretch hold) or by two (shrink skip).
- A resync loads the clamped value and drops `timing_en`.
- The interrupt falls only after a frame start, rises only after an address-0 access, and is not lowered by a resync reload.

Only the bench's scenarios can show the whole-frame behaviour:
- frame lengths measured in ticks;
- that the one-shot requests self-clear;
- that a one-tick request is deferred past a resync;
- that stretch and shrink cancel each other;
- that the clamp and the disable bit work.

// File: rtl/qbt_pkg.sv
package qbt_pkg;

  typedef enum logic [1:0] {
    ADDR_MODE   = 2'd0,
    ADDR_PRESET = 2'd1,
    ADDR_CTRL   = 2'd2
  } qbt_addr_e;

  localparam int MODE_DIS_BIT  = 0;
  localparam int CTRL_SYNC_BIT = 0;
  localparam int CTRL_INS_BIT  = 1;
  localparam int CTRL_EXT_BIT  = 2;

  typedef struct packed {
    logic sync;
    logic ins;
    logic ext;
  } qbt_req_t;

  // Correction value limited to the last legal count of a frame.
  function automatic logic [31:0] clamp_preset(input logic [31:0] value,
                                               input logic [31:0] frame_len);
    return (value >= frame_len) ? frame_len - 32'd1 : value;
  endfunction

  // Count step for an ordinary tick; a pending shrink skips one position.
  function automatic logic [31:0] step_count(input logic [31:0] cnt,
                                             input logic skip);
    return skip ? cnt + 32'd2 : cnt + 32'd1;
  endfunction

endpackage

// File: rtl/qbt_host_regs.sv
module qbt_host_regs
  import qbt_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [1:0]       host_addr,
  input  logic [CNT_W-1:0] host_wdata,
  input  logic             clr_sync,
  input  logic             clr_adj,
  output logic             dis_irq,
  output logic [CNT_W-1:0] preset_q,
  output qbt_req_t         req_q,
  output logic             mode_access
);

  logic ctrl_wr;

  assign mode_access = (host_we || host_re) && (host_addr == ADDR_MODE);
  assign ctrl_wr     = host_we && (host_addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_irq  <= 1'b0;
      preset_q <= '0;
      req_q    <= '0;
    end else begin
      if (host_we && host_addr == ADDR_MODE)
        dis_irq <= host_wdata[MODE_DIS_BIT];
      if (host_we && host_addr == ADDR_PRESET)
        preset_q <= host_wdata;
      // A fresh request written in the clearing cycle survives.
      req_q.sync <= (req_q.sync && !clr_sync) || (ctrl_wr && host_wdata[CTRL_SYNC_BIT]);
      req_q.ins  <= (req_q.ins  && !clr_adj)  || (ctrl_wr && host_wdata[CTRL_INS_BIT]);
      req_q.ext  <= (req_q.ext  && !clr_adj)  || (ctrl_wr && host_wdata[CTRL_EXT_BIT]);
    end
  end

endmodule

// File: rtl/qbt_frame_counter.sv
module qbt_frame_counter
  import qbt_pkg::*;
#(
  parameter int FRAME_LEN = 5000,
  parameter int CNT_W     = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  qbt_req_t         req,
  input  logic [CNT_W-1:0] preset_cl,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             sync_apply,
  output logic             adj_done,
  output logic             sync_frame,
  output logic             hold_q,
  output logic             skip_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic do_ins, do_ext;

  assign wrap_evt   = tick && (count == LAST);
  assign sync_apply = wrap_evt && req.sync;
  assign adj_done   = wrap_evt && !req.sync && (req.ins || req.ext);
  assign do_ins     = adj_done && req.ins && !req.ext;
  assign do_ext     = adj_done && req.ext && !req.ins;

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      hold_q     <= 1'b0;
      skip_q     <= 1'b0;
      sync_frame <= 1'b0;
    end else if (tick) begin
      if (wrap_evt) begin
        count      <= sync_apply ? preset_cl : '0;
        hold_q     <= do_ins;
        skip_q     <= do_ext;
        sync_frame <= sync_apply;
      end else if (hold_q) begin
        hold_q <= 1'b0;
      end else begin
        count  <= CNT_W'(step_count(32'(count), skip_q));
        skip_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qbt_irq_ctrl.sv
module qbt_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wrap_evt,
  input  logic sync_apply,
  input  logic dis_irq,
  input  logic mode_access,
  output logic irq_set,
  output logic frame_irq_n
);

  assign irq_set = wrap_evt && !sync_apply && !dis_irq;

  always_ff @(posedge clk) begin
    if (rst)
      frame_irq_n <= 1'b1;
    else if (irq_set)
      frame_irq_n <= 1'b0;
    else if (mode_access)
      frame_irq_n <= 1'b1;
  end

endmodule

// File: rtl/qbt_timebase.sv
module qbt_timebase
  import qbt_pkg::*;
#(
  parameter int FRAME_LEN = 5000,
  parameter int CNT_W     = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [1:0]       host_addr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] count,
  output logic             frame_irq_n,
  output logic             timing_en
);

  qbt_req_t         req_q;
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] preset_cl;
  logic             dis_irq, mode_access;
  logic             wrap_evt, sync_apply, adj_done, sync_frame;
  logic             hold_q, skip_q, irq_set;
  logic             sync_req;

  assign preset_cl = CNT_W'(clamp_preset(32'(preset_q), 32'(FRAME_LEN)));
  assign sync_req  = req_q.sync;
  assign timing_en = !sync_frame;

  qbt_host_regs #(.CNT_W(CNT_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .clr_sync   (sync_apply),
    .clr_adj    (adj_done),
    .dis_irq    (dis_irq),
    .preset_q   (preset_q),
    .req_q      (req_q),
    .mode_access(mode_access)
  );

  qbt_frame_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .req       (req_q),
    .preset_cl (preset_cl),
    .count     (count),
    .wrap_evt  (wrap_evt),
    .sync_apply(sync_apply),
    .adj_done  (adj_done),
    .sync_frame(sync_frame),
    .hold_q    (hold_q),
    .skip_q    (skip_q)
  );

  qbt_irq_ctrl irq_i (
    .clk        (clk),
    .rst        (rst),
    .wrap_evt   (wrap_evt),
    .sync_apply (sync_apply),
    .dis_irq    (dis_irq),
    .mode_access(mode_access),
    .irq_set    (irq_set),
    .frame_irq_n(frame_irq_n)
  );

endmodule

// File: rtl/qbt_timebase_chk.sv
module qbt_timebase_chk #(
  parameter int FRAME_LEN = 5000,
  parameter int CNT_W     = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic             frame_irq_n,
  input logic             timing_en,
  input logic             wrap_evt,
  input logic             sync_apply,
  input logic             hold_q,
  input logic             skip_q,
  input logic [CNT_W-1:0] preset_cl,
  input logic             mode_access
);

  assert_count_range_R1: assert property (@(posedge clk) disable iff (rst)
    count < CNT_W'(FRAME_LEN));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap_evt && !hold_q && !skip_q) |=> (count == $past(count) + 1'b1));

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && !sync_apply) |=> (count == '0));

  assert_irq_source_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_irq_n) |-> $past(wrap_evt));

  assert_irq_release_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_irq_n) |-> $past(mode_access));

  assert_sync_load_R4: assert property (@(posedge clk) disable iff (rst)
    sync_apply |=> (!timing_en && count == $past(preset_cl)));

  assert_sync_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (sync_apply && frame_irq_n) |=> frame_irq_n);

  assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && hold_q) |=> (count == '0));

  assert_shrink_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && skip_q) |=> (count == CNT_W'(2)));

endmodule

bind qbt_timebase qbt_timebase_chk #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .count      (count),
  .frame_irq_n(frame_irq_n),
  .timing_en  (timing_en),
  .wrap_evt   (wrap_evt),
  .sync_apply (sync_apply),
  .hold_q     (hold_q),
  .skip_q     (skip_q),
  .preset_cl  (preset_cl),
  .mode_access(mode_access)
);

// File: tb/qbt_timebase_tb_top.sv
module qbt_timebase_tb_top;

  localparam int FL = 12;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          host_we = 1'b0;
  logic          host_re = 1'b0;
  logic [1:0]    host_addr = '0;
  logic [CW-1:0] host_wdata = '0;
  logic [CW-1:0] count;
  logic          frame_irq_n;
  logic          timing_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  qbt_timebase #(.FRAME_LEN(FL), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .tick(tick),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata),
    .count(count), .frame_irq_n(frame_irq_n), .timing_en(timing_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(input bit t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic host(input bit we, input bit re, input logic [1:0] a, input int d);
    host_we = we; host_re = re; host_addr = a; host_wdata = CW'(d); tick = 1'b0;
    @(negedge clk);
    host_we = 1'b0; host_re = 1'b0;
  endtask

  // Release the interrupt, tick through one frame, measure its length.
  task automatic frame(input int exp_len, input bit exp_irq, input bit exp_te_low,
                       input string req);
    int  len = 0;
    bit  was_last;
    bit  te_low_all = 1;
    bit  te_high_all = 1;
    host(0, 1, 2'd0, 0);
    do begin
      was_last = (count == CW'(FL - 1));
      if (timing_en) te_low_all = 0; else te_high_all = 0;
      cyc(1);
      len++;
    end while (!was_last && len < 100);
    chk(len == exp_len, {req, " length"}, len, exp_len);
    chk(frame_irq_n == !exp_irq, {req, " irq"}, int'(frame_irq_n), int'(!exp_irq));
    chk(exp_te_low ? te_low_all : te_high_all, {req, " timing_en"},
        int'(exp_te_low ? te_low_all : te_high_all), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R2 reset state
    chk(count == '0, "R2 count", int'(count), 0);
    chk(frame_irq_n == 1'b1, "R2 irq_n", int'(frame_irq_n), 1);
    chk(timing_en == 1'b1, "R2 timing_en", int'(timing_en), 1);
    rst = 1'b0;

    // R1 exhaustive sweep over two frames with idle gaps
    for (int i = 1; i <= 2 * FL; i++) begin
      if (i % 5 == 0) begin
        cyc(0);
        chk(count == CW'((i - 1) % FL), "R1 hold", int'(count), (i - 1) % FL);
      end
      cyc(1);
      chk(count == CW'(i % FL), "R1 step", int'(count), i % FL);
      if (i == FL) chk(frame_irq_n == 1'b0, "R3 frame start", int'(frame_irq_n), 0);
    end

    // R3 interrupt stays low until an address-0 access
    cyc(0); cyc(0);
    chk(frame_irq_n == 1'b0, "R3 held", int'(frame_irq_n), 0);
    host(0, 1, 2'd1, 0);
    chk(frame_irq_n == 1'b0, "R3 other addr", int'(frame_irq_n), 0);
    host(0, 1, 2'd0, 0);
    chk(frame_irq_n == 1'b1, "R3 read release", int'(frame_irq_n), 1);
    frame(FL, 1, 0, "R3 frame");
    host(1, 0, 2'd0, 0);
    chk(frame_irq_n == 1'b1, "R3 write release", int'(frame_irq_n), 1);

    // R11 disable bit and empty request write
    host(1, 0, 2'd0, 1);
    frame(FL, 0, 0, "R11 disabled");
    host(1, 0, 2'd0, 0);
    host(1, 0, 2'd2, 0);
    frame(FL, 1, 0, "R11 zero request");
    frame(FL, 1, 0, "R11 zero request next");

    // R7 stretch: request bit 1
    host(1, 0, 2'd2, 2);
    frame(FL, 1, 0, "R7 request frame");
    frame(FL + 1, 1, 0, "R7 stretched");
    frame(FL, 1, 0, "R7 one-shot");

    // R8 shrink: request bit 2
    host(1, 0, 2'd2, 4);
    frame(FL, 1, 0, "R8 request frame");
    frame(FL - 1, 1, 0, "R8 shrunk");
    frame(FL, 1, 0, "R8 one-shot");

    // R9 both together cancel
    host(1, 0, 2'd2, 6);
    frame(FL, 1, 0, "R9 request frame");
    frame(FL, 1, 0, "R9 cancelled");
    frame(FL, 1, 0, "R9 after");

    // R4 resync with correction 5, R5 self-clear
    host(1, 0, 2'd1, 5);
    host(1, 0, 2'd2, 1);
    frame(FL, 0, 0, "R4 frame N");
    chk(count == CW'(5), "R4 loaded", int'(count), 5);
    chk(timing_en == 1'b0, "R4 timing off", int'(timing_en), 0);
    frame(FL - 5, 1, 1, "R4 corrective");
    chk(timing_en == 1'b1, "R4 timing back", int'(timing_en), 1);
    frame(FL, 1, 0, "R5 no repeat");

    // R6 clamp above range and zero value
    host(1, 0, 2'd1, 31);
    host(1, 0, 2'd2, 1);
    frame(FL, 0, 0, "R6 frame N high");
    chk(count == CW'(FL - 1), "R6 clamped load", int'(count), FL - 1);
    frame(1, 1, 1, "R6 one-tick frame");
    frame(FL, 1, 0, "R6 after high");
    host(1, 0, 2'd1, 0);
    host(1, 0, 2'd2, 1);
    frame(FL, 0, 0, "R6 frame N zero");
    frame(FL, 1, 1, "R6 zero corrective");
    frame(FL, 1, 0, "R6 after zero");

    // R10 resync together with stretch
    host(1, 0, 2'd1, 4);
    host(1, 0, 2'd2, 3);
    frame(FL, 0, 0, "R10 frame N");
    frame(FL - 4, 1, 1, "R10 corrective");
    frame(FL + 1, 1, 0, "R10 deferred stretch");
    frame(FL, 1, 0, "R10 after");

    // R2 reset discards a pending request
    host(1, 0, 2'd2, 2);
    host(0, 1, 2'd0, 0);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    chk(count == '0, "R2 reset count", int'(count), 0);
    chk(frame_irq_n == 1'b1, "R2 reset irq", int'(frame_irq_n), 1);
    frame(FL, 1, 0, "R2 after reset");
    frame(FL, 1, 0, "R2 request dropped");

    summary();
  end

endmodule